// File: doc/BRIEF.md
# Delayed LCD Control Pulse Generator

This block produces a one-dot-clock control strobe for a TFT panel. The strobe is placed a programmable number of dot-clock cycles after each rising edge of the horizontal sync input. A single configuration byte, written from the CPU side, sets four things: the delay (0 to 15 cycles), an enable that gates the strobe, a polarity select, and a software-driven panel reset level that goes straight to a dedicated output pin.

Horizontal sync arrives without any timing relationship to the dot clock. It passes through a two-stage synchronizer and then through an edge detector, which feeds a small state machine. The machine has three states. `ST_IDLE` waits for a sync edge. `ST_COUNT` counts down the captured delay. `ST_FIRE` is the single cycle in which the strobe is asserted. The transitions are: T_IDLE_FIRE (edge seen, delay 0), T_IDLE_COUNT (edge seen, delay above 0), T_COUNT_COUNT (count still above 1), T_COUNT_FIRE (count reaches 1) and T_FIRE_IDLE (always, after one cycle).

The active-low power-fault input clears every register asynchronously, including the configuration, the synchronizer and the state machine. The block has no power-enable input, and no other input affects it. The configuration port is assumed to be synchronous to the dot clock.

Top module: `lcd_strobe_gen`

## Requirements
- R1: While `pwr_fault_n` is low, every register is cleared. `strobe_o` is 0, `panel_rst_o` is 0, and a delay count in progress is abandoned, so no strobe follows once the fault is released.
- R2: A write (`cfg_we` high at a rising edge of `clk`) loads `cfg_wdata`, with these fields: bits [3:0] are the delay, bit 4 is the enable, bit 5 is the invert select, and bit 6 is the panel reset level. Bit 7 has no effect.
- R3: `panel_rst_o` equals the bit 6 value from the most recent write, starting at the clock edge that performs the write.
- R4: Suppose `hsync_in` is first seen high at rising edge P1. The strobe is then active during the cycle that follows rising edge P(3+d), where d is the delay field.
- R5: The strobe is active for exactly one dot-clock cycle per accepted sync edge.
- R6: Any delay from 0 to 15 is honoured. The delay is captured when the sync edge is detected, so a write to the field during a count does not move the pending strobe.
- R7: No further strobe is produced by a sync input held high, or by a sync rising edge detected while a count or strobe is in progress.
- R8: While the enable bit is 0, `strobe_o` stays constant at the invert bit value.
- R9: With invert 0 the strobe is active high and rests low. With invert 1 it is active low and rests high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| pwr_fault_n | input | 1 | Active-low power fault; asynchronously clears all registers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte (fields as in R2) |
| hsync_in | input | 1 | Horizontal sync, asynchronous to `clk` |
| strobe_o | output | 1 | Delayed panel control strobe |
| panel_rst_o | output | 1 | Panel reset level from the configuration |

## Verification
The states that are hard to reach from the ports are the ones where something interrupts a count already in flight. These are a second sync rising edge, a rewrite of the delay field, and a power fault, each arriving while the machine sits in `ST_COUNT`. The bench raises sync and then, at chosen dot-clock cycles inside the countdown, re-pulses sync, rewrites the configuration, or pulls the fault input low. It then checks the strobe on every cycle of the line. Random lines with delays that include 0 and 15 exercise the latency boundaries.

// File: rtl/lcd_strobe_pkg.sv
package lcd_strobe_pkg;

    parameter int DLY_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } strobe_st_e;

    typedef struct packed {
        logic             pnl_rst;
        logic             invert;
        logic             enable;
        logic [DLY_W-1:0] delay;
    } strobe_cfg_t;

endpackage

// File: rtl/lcd_strobe_cfg.sv
module lcd_strobe_cfg
    import lcd_strobe_pkg::*;
#(
    parameter int CW = DLY_W + 3
) (
    input  logic          clk,
    input  logic          pwr_fault_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output strobe_cfg_t   cfg
);

    strobe_cfg_t cfg_q;

    always_ff @(posedge clk or negedge pwr_fault_n) begin
        if (!pwr_fault_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= strobe_cfg_t'(wr_data);
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/lcd_strobe_hsync.sv
module lcd_strobe_hsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pwr_fault_n,
    input  logic hsync_in,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge pwr_fault_n) begin
                    if (!pwr_fault_n) sync_q[s] <= 1'b0;
                    else              sync_q[s] <= hsync_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge pwr_fault_n) begin
                    if (!pwr_fault_n) sync_q[s] <= 1'b0;
                    else              sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge pwr_fault_n) begin
        if (!pwr_fault_n) last_q <= 1'b0;
        else              last_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/lcd_strobe_fsm.sv
module lcd_strobe_fsm
    import lcd_strobe_pkg::*;
(
    input  logic             clk,
    input  logic             pwr_fault_n,
    input  logic             rise,
    input  logic [DLY_W-1:0] delay,
    output strobe_st_e       state,
    output logic [DLY_W-1:0] count,
    output logic             fire
);

    localparam logic [DLY_W-1:0] CNT_ONE  = DLY_W'(1);
    localparam logic [DLY_W-1:0] CNT_ZERO = '0;

    strobe_st_e       st_q, st_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge pwr_fault_n) begin
        if (!pwr_fault_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= CNT_ZERO;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (rise) begin
                    if (delay == CNT_ZERO) begin
                        st_d = ST_FIRE;          // T_IDLE_FIRE
                    end else begin
                        st_d  = ST_COUNT;        // T_IDLE_COUNT
                        cnt_d = delay;
                    end
                end
            end
            ST_COUNT: begin
                if (cnt_q == CNT_ONE) begin
                    st_d  = ST_FIRE;             // T_COUNT_FIRE
                    cnt_d = CNT_ZERO;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;     // T_COUNT_COUNT
                end
            end
            ST_FIRE: begin
                st_d = ST_IDLE;                  // T_FIRE_IDLE
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = CNT_ZERO;
            end
        endcase
    end

    // outputs
    always_comb begin
        fire = (st_q == ST_FIRE);
    end

    assign state = st_q;
    assign count = cnt_q;

endmodule

// File: rtl/lcd_strobe_out.sv
module lcd_strobe_out (
    input  logic fire,
    input  logic enable,
    input  logic invert,
    output logic strobe
);

    always_comb begin
        if (enable) strobe = fire ^ invert;
        else        strobe = invert;
    end

endmodule

// File: rtl/lcd_strobe_gen.sv
module lcd_strobe_gen
    import lcd_strobe_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CFG_W       = 8
) (
    input  logic             clk,
    input  logic             pwr_fault_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             hsync_in,
    output logic             strobe_o,
    output logic             panel_rst_o
);

    localparam int USED_W = DLY_W + 3;

    strobe_cfg_t      cfg;
    logic             hs_rise;
    strobe_st_e       fsm_state;
    logic [DLY_W-1:0] fsm_count;
    logic             fsm_fire;
    logic [CFG_W-1:USED_W] unused_cfg_bits;

    assign unused_cfg_bits = cfg_wdata[CFG_W-1:USED_W];

    lcd_strobe_cfg #(.CW(USED_W)) u_cfg (
        .clk         (clk),
        .pwr_fault_n (pwr_fault_n),
        .wr_en       (cfg_we),
        .wr_data     (cfg_wdata[USED_W-1:0]),
        .cfg         (cfg)
    );

    lcd_strobe_hsync #(.STAGES(SYNC_STAGES)) u_hsync (
        .clk         (clk),
        .pwr_fault_n (pwr_fault_n),
        .hsync_in    (hsync_in),
        .rise        (hs_rise)
    );

    lcd_strobe_fsm u_fsm (
        .clk         (clk),
        .pwr_fault_n (pwr_fault_n),
        .rise        (hs_rise),
        .delay       (cfg.delay),
        .state       (fsm_state),
        .count       (fsm_count),
        .fire        (fsm_fire)
    );

    lcd_strobe_out u_out (
        .fire   (fsm_fire),
        .enable (cfg.enable),
        .invert (cfg.invert),
        .strobe (strobe_o)
    );

    assign panel_rst_o = cfg.pnl_rst;

endmodule

// File: rtl/lcd_strobe_chk.sv
module lcd_strobe_chk
    import lcd_strobe_pkg::*;
(
    input logic             clk,
    input logic             pwr_fault_n,
    input logic             cfg_we,
    input logic [7:0]       cfg_wdata,
    input logic             strobe_o,
    input logic             panel_rst_o,
    input logic             en,
    input logic             inv,
    input strobe_st_e       state,
    input logic [DLY_W-1:0] count
);

    assert_fault_clear_R1: assert property (@(posedge clk)
        !pwr_fault_n |-> (!strobe_o && !panel_rst_o && state == ST_IDLE));

    assert_rst_follows_R3: assert property (@(posedge clk) disable iff (!pwr_fault_n)
        cfg_we |=> (panel_rst_o == $past(cfg_wdata[6])));

    assert_single_cycle_R5: assert property (@(posedge clk) disable iff (!pwr_fault_n)
        (en && strobe_o != inv && !cfg_we) |=> (strobe_o == inv));

    assert_count_live_R6: assert property (@(posedge clk) disable iff (!pwr_fault_n)
        (state == ST_COUNT) |-> (count != '0));

    assert_disabled_rest_R8: assert property (@(posedge clk) disable iff (!pwr_fault_n)
        !en |-> (strobe_o == inv));

endmodule

bind lcd_strobe_gen lcd_strobe_chk chk_i (
    .clk         (clk),
    .pwr_fault_n (pwr_fault_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .strobe_o    (strobe_o),
    .panel_rst_o (panel_rst_o),
    .en          (cfg.enable),
    .inv         (cfg.invert),
    .state       (fsm_state),
    .count       (fsm_count)
);

// File: tb/lcd_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_strobe_gen_tb_top;

    logic       clk = 1'b0;
    logic       pwr_fault_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       hsync_in = 1'b0;
    logic       strobe_o;
    logic       panel_rst_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lcd_strobe_gen dut_i (
        .clk         (clk),
        .pwr_fault_n (pwr_fault_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .hsync_in    (hsync_in),
        .strobe_o    (strobe_o),
        .panel_rst_o (panel_rst_o)
    );

    function automatic logic cfg_byte_unused(input int x);
        return x != 0;
    endfunction

    // expected strobe level at negedge i after sync raise
    function automatic logic exp_strobe(input int i, input int d, input logic en, input logic inv);
        if (en && i == 3 + d) return ~inv;
        return inv;
    endfunction

    function automatic logic [7:0] mk_cfg(input int d, input logic en, input logic inv,
                                          input logic rst, input logic b7);
        return {b7, rst, inv, en, 4'(d)};
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one sync line: raise at current negedge, check every cycle
    task automatic run_line(input int d, input logic en, input logic inv,
                            input int hi_len, input string tag);
        hsync_in = 1'b1;
        for (int i = 1; i <= d + 7; i++) begin
            @(negedge clk);
            chk(strobe_o, exp_strobe(i, d, en, inv), tag);
            if (i == hi_len) hsync_in = 1'b0;
        end
        hsync_in = 1'b0;
        idle(2);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd7411);
        idle(3);
        // R1 reset state
        chk(strobe_o, 1'b0, "R1 strobe under fault");
        chk(panel_rst_o, 1'b0, "R1 panel reset under fault");
        pwr_fault_n = 1'b1;
        idle(3);
        chk(strobe_o, 1'b0, "R1 strobe after release");

        // R2/R3 panel reset bit
        cfg_write(mk_cfg(0, 1'b0, 1'b0, 1'b1, 1'b0));
        chk(panel_rst_o, 1'b1, "R3 panel reset set");
        chk(strobe_o, 1'b0, "R2 other fields clear");
        cfg_write(mk_cfg(0, 1'b0, 1'b1, 1'b0, 1'b1));
        chk(panel_rst_o, 1'b0, "R3 panel reset clear");
        chk(strobe_o, 1'b1, "R9 disabled rest follows invert");

        // directed delays 0 and 15, both polarities
        cfg_write(mk_cfg(0, 1'b1, 1'b0, 1'b0, 1'b0));
        idle(2);
        run_line(0, 1'b1, 1'b0, 1, "R4 delay 0");
        cfg_write(mk_cfg(15, 1'b1, 1'b1, 1'b0, 1'b0));
        idle(2);
        run_line(15, 1'b1, 1'b1, 20, "R6 delay 15 inverted, R7 held high");

        // R7 retrigger during count
        cfg_write(mk_cfg(10, 1'b1, 1'b0, 1'b0, 1'b0));
        idle(2);
        hsync_in = 1'b1;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            chk(strobe_o, exp_strobe(i, 10, 1'b1, 1'b0), "R7 retrigger ignored");
            if (i == 2 || i == 8) hsync_in = 1'b0;
            if (i == 5) hsync_in = 1'b1;
        end
        idle(3);

        // R6 delay rewrite during count
        cfg_write(mk_cfg(8, 1'b1, 1'b0, 1'b0, 1'b0));
        idle(2);
        hsync_in = 1'b1;
        for (int i = 1; i <= 18; i++) begin
            @(negedge clk);
            chk(strobe_o, exp_strobe(i, 8, 1'b1, 1'b0), "R6 captured delay");
            if (i == 2) hsync_in = 1'b0;
            if (i == 5) begin
                cfg_we = 1'b1;
                cfg_wdata = mk_cfg(2, 1'b1, 1'b0, 1'b0, 1'b0);
            end
            if (i == 6) cfg_we = 1'b0;
        end
        idle(2);

        // R1 fault mid count
        cfg_write(mk_cfg(12, 1'b1, 1'b0, 1'b1, 1'b0));
        idle(2);
        hsync_in = 1'b1;
        idle(2);
        hsync_in = 1'b0;
        idle(3);
        pwr_fault_n = 1'b0;
        @(negedge clk);
        chk(strobe_o, 1'b0, "R1 strobe cleared mid count");
        chk(panel_rst_o, 1'b0, "R1 panel reset cleared");
        pwr_fault_n = 1'b1;
        cfg_write(mk_cfg(12, 1'b1, 1'b0, 1'b0, 1'b0));
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(strobe_o, 1'b0, "R1 count abandoned");
        end

        // random lines
        for (int n = 0; n < 60; n++) begin
            int d;
            logic en, inv, b7;
            int hi;
            d   = int'($urandom_range(0, 15));
            en  = logic'($urandom_range(0, 3) != 0);
            inv = logic'($urandom_range(0, 1));
            b7  = logic'($urandom_range(0, 1));
            hi  = int'($urandom_range(1, 5));
            cfg_write(mk_cfg(d, en, inv, 1'b0, b7));
            chk(strobe_o, inv, "R8 R9 rest level");
            idle(1);
            run_line(d, en, inv, hi, en ? "R4 R5 random line" : "R8 disabled line");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule